// File: doc/BRIEF.md
# Scatter DMA Descriptor Table Builder

This block turns a transfer request into a chain of scatter descriptors for a DMA engine. A request gives a buffer base address, a block count and a block size. The block multiplies count and size into a byte total. It cuts that total into chunks of at most 64 KiB and writes one 64-bit descriptor per chunk through a write port into an external descriptor RAM. When the chain is complete, it hands the table's base address to the DMA engine.

The length field of a descriptor is 16 bits wide, so a full 64 KiB chunk is encoded as zero. Only the final descriptor carries the end marker. A request that would need more descriptors than the table holds is refused with a one-cycle error pulse. In that case nothing is written and the address given to the DMA engine does not change. The host starts a request with a one-cycle strobe and waits for either the done pulse or the error pulse.

Top module: `dtb_table_builder`

## Requirements
- R1: Each descriptor word carries the buffer address in bits [63:32] and the length in bits [31:16]. Bits [15:6] and [3:2] are zero. The attribute field sits in bits [5:0]: valid at bit 0, end at bit 1, and the action code "transfer" as 2'b10 in bits [5:4].
- R2: The byte total is blk_cnt times the block size. A blk_size input of zero selects the default block size of 512 bytes.
- R3: A request writes exactly N descriptors, at table indices 0 to N-1, one per cycle. N is 1 when the total is below 65536. Otherwise N is total/65536, plus 1 when there is a remainder.
- R4: Descriptor k holds the address buf_base + k*65536, modulo 2^32.
- R5: Every descriptor except the last has a length field of 0 (meaning 65536) and attributes valid plus transfer, with the end bit clear.
- R6: The last descriptor has valid, transfer and end set. Its length field is total - (N-1)*65536 taken modulo 65536, so a final chunk of exactly 64 KiB encodes as 0.
- R7: When N exceeds the table depth of 32, err pulses for one cycle, one cycle after the start is accepted. No descriptor is written, done does not pulse, and sys_addr keeps its value.
- R8: One cycle after the last descriptor write, done pulses for one cycle and sys_addr is loaded with the TABLE_BASE parameter.
- R9: A start strobe while busy is high is ignored and does not change the descriptors being written.
- R10: When a start is accepted at clock edge t, busy is high from t on. The first write is visible after edge t+2. done is visible after edge t+N+2, and busy falls together with done or err.
- R11: After reset, busy, ram_we, done and err are low, and sys_addr is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request strobe |
| buf_base | input | ADDR_W | Buffer base byte address |
| blk_cnt | input | CNT_W | Number of blocks |
| blk_size | input | BSZ_W | Block size in bytes; 0 selects the default |
| busy | output | 1 | Request in progress |
| ram_we | output | 1 | Descriptor RAM write enable |
| ram_idx | output | IDX_W | Descriptor RAM write index |
| ram_wdata | output | ADDR_W+32 | Descriptor word |
| sys_addr | output | ADDR_W | Table base address presented to the DMA engine |
| done | output | 1 | Table complete pulse |
| err | output | 1 | Request refused pulse |

## Verification
The hardest cases to reach from the ports are the capacity boundary and a final chunk that fills exactly 64 KiB. A total of exactly 32*65536 bytes must fill the table with a zero-length last entry, and one more block must be refused. The stimulus reaches both by choosing block counts of 4096 and 4097 at 512 bytes. It also requests exactly 65536 bytes, which must give a single descriptor. A start pulsed in the middle of a chain, and an address base near the top of the address space, check that accepted state is held and that address arithmetic wraps.

// File: rtl/dtb_pkg.sv
package dtb_pkg;
  localparam int LEN_W  = 16;
  localparam int ATTR_W = 6;
  localparam int PAD_W  = 32 - LEN_W - ATTR_W;

  localparam logic [ATTR_W-1:0] ATTR_VALID = 6'b000001;
  localparam logic [ATTR_W-1:0] ATTR_END   = 6'b000010;
  localparam logic [ATTR_W-1:0] ATTR_XFER  = 6'b100000;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHECK,
    ST_EMIT,
    ST_LOAD
  } seq_state_t;
endpackage

// File: rtl/dtb_sizer.sv
module dtb_sizer #(
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 16,
  parameter int BSZ_W   = 12,
  parameter int DEF_BSZ = 512,
  localparam int TOT_W  = CNT_W + BSZ_W,
  localparam int NCNT_W = TOT_W - dtb_pkg::LEN_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] buf_base,
  input  logic [CNT_W-1:0]  blk_cnt,
  input  logic [BSZ_W-1:0]  blk_size,
  output logic [ADDR_W-1:0] base_q,
  output logic [TOT_W-1:0]  total_q,
  output logic [NCNT_W-1:0] desc_cnt
);
  import dtb_pkg::*;

  logic [BSZ_W-1:0]        eff_bsz;
  logic [TOT_W-1:0]        product;
  logic [NCNT_W-2:0]       whole;
  logic                    frac;

  assign eff_bsz = (blk_size == '0) ? BSZ_W'(DEF_BSZ) : blk_size;
  assign product = TOT_W'(blk_cnt) * TOT_W'(eff_bsz);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      total_q <= '0;
    end else if (load) begin
      base_q  <= buf_base;
      total_q <= product;
    end
  end

  assign whole = total_q[TOT_W-1:LEN_W];
  assign frac  = |total_q[LEN_W-1:0];

  always_comb begin
    if (whole == '0) desc_cnt = NCNT_W'(1);
    else             desc_cnt = {1'b0, whole} + NCNT_W'(frac);
  end
endmodule

// File: rtl/dtb_seq.sv
module dtb_seq #(
  parameter int DEPTH  = 32,
  parameter int NCNT_W = 13,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [NCNT_W-1:0] desc_cnt,
  output logic              accept,
  output logic              busy,
  output logic              emit,
  output logic              last,
  output logic [IDX_W-1:0]  idx,
  output logic              reject,
  output logic              finish
);
  import dtb_pkg::*;

  seq_state_t       state;
  logic [IDX_W-1:0] last_idx;
  logic             too_many;

  assign too_many = desc_cnt > NCNT_W'(DEPTH);
  assign accept   = start && (state == ST_IDLE);
  assign busy     = (state != ST_IDLE);
  assign emit     = (state == ST_EMIT);
  assign last     = emit && (idx == last_idx);
  assign reject   = (state == ST_CHECK) && too_many;
  assign finish   = (state == ST_LOAD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      idx      <= '0;
      last_idx <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) state <= ST_CHECK;
        ST_CHECK: begin
          idx      <= '0;
          last_idx <= IDX_W'(desc_cnt - NCNT_W'(1));
          state    <= too_many ? ST_IDLE : ST_EMIT;
        end
        ST_EMIT: begin
          if (idx == last_idx) state <= ST_LOAD;
          else                 idx   <= idx + IDX_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dtb_pack.sv
module dtb_pack #(
  parameter int               ADDR_W     = 32,
  parameter int               TOT_W      = 28,
  parameter int               IDX_W      = 5,
  parameter logic [ADDR_W-1:0] TABLE_BASE = '0,
  localparam int              DESC_W     = ADDR_W + 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              emit,
  input  logic              last,
  input  logic [IDX_W-1:0]  idx,
  input  logic [ADDR_W-1:0] base_q,
  input  logic [TOT_W-1:0]  total_q,
  input  logic              reject,
  input  logic              finish,
  output logic              ram_we,
  output logic [IDX_W-1:0]  ram_idx,
  output logic [DESC_W-1:0] ram_wdata,
  output logic [ADDR_W-1:0] sys_addr,
  output logic              done,
  output logic              err
);
  import dtb_pkg::*;

  logic [ADDR_W-1:0] ent_addr;
  logic [TOT_W-1:0]  covered;
  logic [LEN_W-1:0]  ent_len;
  logic [ATTR_W-1:0] ent_attr;

  assign ent_addr = base_q + (ADDR_W'(idx) << LEN_W);
  assign covered  = TOT_W'(idx) << LEN_W;

  generate
    if (TOT_W > LEN_W) begin : g_len_wide
      logic [TOT_W-1:0] rest;
      assign rest    = total_q - covered;
      assign ent_len = last ? rest[LEN_W-1:0] : '0;
    end else begin : g_len_narrow
      assign ent_len = last ? LEN_W'(total_q - covered) : '0;
    end
  endgenerate

  assign ent_attr = ATTR_XFER | ATTR_VALID | (last ? ATTR_END : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_we    <= 1'b0;
      ram_idx   <= '0;
      ram_wdata <= '0;
      sys_addr  <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      ram_we <= emit;
      done   <= finish;
      err    <= reject;
      if (emit) begin
        ram_idx   <= idx;
        ram_wdata <= {ent_addr, ent_len, {PAD_W{1'b0}}, ent_attr};
      end
      if (finish) sys_addr <= TABLE_BASE;
    end
  end
endmodule

// File: rtl/dtb_table_builder.sv
module dtb_table_builder #(
  parameter int               ADDR_W     = 32,
  parameter int               CNT_W      = 16,
  parameter int               BSZ_W      = 12,
  parameter int               DEF_BSZ    = 512,
  parameter int               DEPTH      = 32,
  parameter logic [ADDR_W-1:0] TABLE_BASE = 32'h0001_0000,
  localparam int              IDX_W      = $clog2(DEPTH),
  localparam int              TOT_W      = CNT_W + BSZ_W,
  localparam int              NCNT_W     = TOT_W - dtb_pkg::LEN_W + 1,
  localparam int              DESC_W     = ADDR_W + 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] buf_base,
  input  logic [CNT_W-1:0]  blk_cnt,
  input  logic [BSZ_W-1:0]  blk_size,
  output logic              busy,
  output logic              ram_we,
  output logic [IDX_W-1:0]  ram_idx,
  output logic [DESC_W-1:0] ram_wdata,
  output logic [ADDR_W-1:0] sys_addr,
  output logic              done,
  output logic              err
);
  logic              accept, emit, last, reject, finish;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] base_q;
  logic [TOT_W-1:0]  total_q;
  logic [NCNT_W-1:0] desc_cnt;

  dtb_sizer #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BSZ_W(BSZ_W), .DEF_BSZ(DEF_BSZ)
  ) u_sizer (
    .clk(clk), .rst(rst), .load(accept), .buf_base(buf_base),
    .blk_cnt(blk_cnt), .blk_size(blk_size),
    .base_q(base_q), .total_q(total_q), .desc_cnt(desc_cnt)
  );

  dtb_seq #(.DEPTH(DEPTH), .NCNT_W(NCNT_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .desc_cnt(desc_cnt),
    .accept(accept), .busy(busy), .emit(emit), .last(last), .idx(idx),
    .reject(reject), .finish(finish)
  );

  dtb_pack #(
    .ADDR_W(ADDR_W), .TOT_W(TOT_W), .IDX_W(IDX_W), .TABLE_BASE(TABLE_BASE)
  ) u_pack (
    .clk(clk), .rst(rst), .emit(emit), .last(last), .idx(idx),
    .base_q(base_q), .total_q(total_q), .reject(reject), .finish(finish),
    .ram_we(ram_we), .ram_idx(ram_idx), .ram_wdata(ram_wdata),
    .sys_addr(sys_addr), .done(done), .err(err)
  );
endmodule

// File: rtl/dtb_checker.sv
module dtb_checker #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 5,
  parameter logic [ADDR_W-1:0] TABLE_BASE = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              ram_we,
  input logic [IDX_W-1:0]  ram_idx,
  input logic [ADDR_W+31:0] ram_wdata,
  input logic [ADDR_W-1:0] sys_addr,
  input logic              done,
  input logic              err
);
  AST_ATTR_FORM: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (ram_wdata[5:4] == 2'b10 && ram_wdata[0] && ram_wdata[3:2] == 2'b00 && ram_wdata[15:6] == '0)); // R1
  AST_FIRST_IDX: assert property (@(posedge clk) disable iff (rst)
    $rose(ram_we) |-> (ram_idx == '0)); // R3
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
    (ram_we && !ram_wdata[1]) |=> (ram_we && ram_idx == $past(ram_idx) + IDX_W'(1))); // R3
  AST_MID_LEN: assert property (@(posedge clk) disable iff (rst)
    (ram_we && !ram_wdata[1]) |-> (ram_wdata[31:16] == '0)); // R5
  AST_END_STOPS: assert property (@(posedge clk) disable iff (rst)
    (ram_we && ram_wdata[1]) |=> (!ram_we && done)); // R8
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
    err |-> (!ram_we && !done && !busy)); // R7
  AST_SYS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(sys_addr)); // R7
  AST_SYS_LOAD: assert property (@(posedge clk) disable iff (rst)
    done |-> (sys_addr == TABLE_BASE && !busy)); // R8
  AST_WE_BUSY: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> busy); // R10
endmodule

bind dtb_table_builder dtb_checker #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .TABLE_BASE(TABLE_BASE)
) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .ram_we(ram_we), .ram_idx(ram_idx),
  .ram_wdata(ram_wdata), .sys_addr(sys_addr), .done(done), .err(err)
);

// File: tb/sim_dtb_table_builder.sv
module sim_dtb_table_builder;
  localparam int CLK_NS = 10;
  localparam logic [31:0] TBASE = 32'h0004_2000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] buf_base = '0;
  logic [15:0] blk_cnt = '0;
  logic [11:0] blk_size = '0;
  logic        busy, ram_we, done, err;
  logic [4:0]  ram_idx;
  logic [63:0] ram_wdata;
  logic [31:0] sys_addr;

  always #(CLK_NS/2) clk = ~clk;

  dtb_table_builder #(.TABLE_BASE(TBASE)) u0 (
    .clk(clk), .rst(rst), .start(start), .buf_base(buf_base),
    .blk_cnt(blk_cnt), .blk_size(blk_size), .busy(busy), .ram_we(ram_we),
    .ram_idx(ram_idx), .ram_wdata(ram_wdata), .sys_addr(sys_addr),
    .done(done), .err(err)
  );

  typedef struct packed {
    logic        busy;
    logic        we;
    logic [4:0]  idx;
    logic [63:0] data;
    logic        done;
    logic        err;
  } obs_t;

  obs_t        exp_q[$];
  logic        prev_busy = 1'b0;
  logic [31:0] sys_exp = '0;
  int          total_chk = 0;
  int          bad_chk = 0;
  string       scen = "R11";

  task automatic chk(string tag, logic ok, logic [63:0] act, logic [63:0] expv);
    total_chk++;
    if (!ok) begin
      bad_chk++;
      $display("FAIL %s %s act=%h exp=%h", scen, tag, act, expv);
    end
  endtask

  // Reference: builds the per-cycle expected outputs of one accepted request.
  task automatic plan_job(logic [31:0] base, logic [15:0] cnt, logic [11:0] bsz);
    longint tot, n, len;
    obs_t r;
    tot = longint'(cnt) * ((bsz == 0) ? 512 : longint'(bsz));
    if (tot < 65536) n = 1;
    else n = tot / 65536 + ((tot % 65536 != 0) ? 1 : 0);
    r = '0; r.busy = 1'b1;
    exp_q.push_back(r);
    if (n > 32) begin
      r = '0; r.err = 1'b1;
      exp_q.push_back(r);
    end else begin
      exp_q.push_back(r);
      for (longint k = 0; k < n; k++) begin
        r = '0; r.busy = 1'b1; r.we = 1'b1; r.idx = 5'(k);
        r.data[63:32] = 32'(longint'(base) + k * 65536);
        if (k == n - 1) begin
          len = (tot - (n - 1) * 65536) % 65536;
          r.data[31:16] = 16'(len);
          r.data[5:0] = 6'b100011;
        end else begin
          r.data[5:0] = 6'b100001;
        end
        exp_q.push_back(r);
      end
      r = '0; r.done = 1'b1;
      exp_q.push_back(r);
    end
  endtask

  task automatic step();
    obs_t r;
    if (start && !prev_busy) plan_job(buf_base, blk_cnt, blk_size);
    @(posedge clk);
    #1;
    r = (exp_q.size() > 0) ? exp_q.pop_front() : '0;
    if (r.done) sys_exp = TBASE;
    chk("R10 busy", busy == r.busy, 64'(busy), 64'(r.busy));
    chk("R3 we", ram_we == r.we, 64'(ram_we), 64'(r.we));
    if (r.we) begin
      chk("R3 idx", ram_idx == r.idx, 64'(ram_idx), 64'(r.idx));
      chk("R4 addr", ram_wdata[63:32] == r.data[63:32], 64'(ram_wdata[63:32]), 64'(r.data[63:32]));
      chk(r.data[1] ? "R6/R1 low word" : "R5/R1 low word",
          ram_wdata[31:0] == r.data[31:0], 64'(ram_wdata[31:0]), 64'(r.data[31:0]));
    end
    chk("R8 done", done == r.done, 64'(done), 64'(r.done));
    chk("R7 err", err == r.err, 64'(err), 64'(r.err));
    chk("R8 sys_addr", sys_addr == sys_exp, 64'(sys_addr), 64'(sys_exp));
    prev_busy = r.busy;
  endtask

  task automatic job(string tag, logic [31:0] base, logic [15:0] cnt,
                     logic [11:0] bsz, bit poke);
    scen = tag;
    buf_base = base; blk_cnt = cnt; blk_size = bsz; start = 1'b1;
    step();
    start = 1'b0;
    for (int c = 0; c < 40 && exp_q.size() > 0; c++) begin
      if (poke && c == 2) begin
        buf_base = 32'hDEAD_0000; blk_cnt = 16'd9; blk_size = 12'd7; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      step();
    end
    start = 1'b0;
    step();
  endtask

  task automatic run_all();
    repeat (3) @(posedge clk);
    #1;
    scen = "R11";
    chk("R11 reset busy", busy == 1'b0, 64'(busy), 64'd0);
    chk("R11 reset we", ram_we == 1'b0, 64'(ram_we), 64'd0);
    chk("R11 reset done/err", {done, err} == 2'b00, 64'({done, err}), 64'd0);
    chk("R11 reset sys_addr", sys_addr == '0, 64'(sys_addr), 64'd0);
    rst = 1'b0;
    step();
    job("R2 default size",       32'h1000_0000, 16'd1,    12'd0,   1'b0);
    job("R3 two chunks",         32'h2000_0000, 16'd129,  12'd512, 1'b0);
    job("R6 exact 64KiB",        32'h3000_0000, 16'd128,  12'd512, 1'b0);
    job("R2 odd size",           32'h0000_1234, 16'd1000, 12'd100, 1'b0);
    job("R4 wrap",               32'hFFFF_0100, 16'd300,  12'd0,   1'b0);
    job("R7 over capacity",      32'h4000_0000, 16'd4097, 12'd512, 1'b0);
    job("R6 full table",         32'h5000_0000, 16'd4096, 12'd512, 1'b0);
    job("R9 start while busy",   32'h6000_0000, 16'd300,  12'd512, 1'b1);
    job("R7 big refuse",         32'h7000_0000, 16'hFFFF, 12'hFFF, 1'b0);
    job("R3 tiny",               32'h8000_0000, 16'd3,    12'd1,   1'b0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (200000) @(posedge clk);
        total_chk++;
        bad_chk++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total_chk, bad_chk);
    $finish;
  end
endmodule